// File: doc/BRIEF.md
# DMA Channel Controller with Transfer Sequencer

This block is one DMA channel that copies a programmed number of bytes or 16-bit words from a source address to a destination address over a simple bus-master port. Software programs the source address, the destination address and a transfer count. It then arms the channel through an 8-bit control register and a companion register, which holds a master enable and the request-source select.

Each transfer is one bus read at the source followed by one bus write at the destination. The source pointer can step up, step down or stay put, and the destination pointer always advances by the transfer size. Transfers are started in one of three ways:

- continuously, in auto-request mode;
- once per external request strobe;
- for the whole remaining count after a single strobe, in block mode.

When the count runs out, the channel clears its own enable. If interrupts are enabled, it raises an interrupt line that stays up until software acknowledges it.

Top module: `dma_chan_seq`

## Requirements
- R1: Register map by `cpu_addr`: 0 control, 1 companion, 2 source address, 3 destination address, 4 count; all read back on `cpu_rdata` (zero-extended). Control bits from bit 7 down: enable, size (0 byte, 1 word), step direction (0 up, 1 down), step enable, interrupt enable, mode2, mode1, mode0. Companion bit 0 is master enable, bit 1 selects auto-request.
- R2: After reset every register reads 0, `bus_req` is 0 and `irq` is 0.
- R3: A write cannot turn the enable bit from 0 to 1 unless the control register was read while enable was 0, and no control write came after that read. Any control write uses up that permission. A written 0 always clears enable, and a written 1 keeps an enable that is already set.
- R4: No transfer starts unless both the enable bit and the master enable are 1.
- R5: No transfer starts unless mode2 and mode1 are both 1.
- R6: A transfer reads at the source and then writes the read data to the destination, with `bus_word` equal to the size bit. Byte transfers carry the data in `bus_wdata[7:0]` with bits 15:8 zero.
- R7: After each transfer the source address is held when step enable is 0. Otherwise it moves by 1 for bytes or 2 for words: up when step direction is 0, down when it is 1.
- R8: After each transfer the destination address increases by 1 for bytes or 2 for words.
- R9: Each transfer decrements the count. The transfer that takes the count from 1 to 0 clears the enable bit.
- R10: At the last transfer, `irq` rises if interrupt enable is 1. It stays high until a control write with interrupt enable 0, or a control write that sets enable from 0 to 1.
- R11: With auto-request, transfers run back to back while the channel is active. Otherwise, one transfer starts for each cycle `dreq` is high while the channel is active and idle, and `dreq` has no effect while the channel is inactive.
- R12: With mode0 = 1 and auto-request off, a single accepted `dreq` runs every remaining transfer down to terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 3 | Register select |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (used for the enable permission) |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data (combinational on `cpu_addr`) |
| dreq | input | 1 | External transfer request |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_word | output | 1 | 1 for a 16-bit cycle, 0 for a byte cycle |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_ack | input | 1 | Bus cycle completion |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The bench first writes a 1 to enable without a preceding read. A design that ignored the read-then-write rule would start moving data at that point. It also arms the channel with the master enable off, and again with an incomplete mode code; a wrong design would issue bus cycles in those cases.

Word transfers with a descending source, and byte transfers with a held source, expose step arithmetic that uses the wrong sign or size. The reference model catches these on the very first wrong address. Checking the upper byte of byte-sized write data catches a design that does not mask the unused half of the bus.

Request handling is probed in two ways. Single strobes must each give exactly one transfer, and a strobe after terminal count must give none. A single strobe in block mode must drain the whole count. Finally, the interrupt is checked against the model on every cycle. This shows up an interrupt that drops on its own, or one that survives re-arming.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_t;

  typedef struct packed {
    logic       en;
    logic       word;
    logic       dec;
    logic       step;
    logic       ie;
    logic [2:0] mode;
  } ctrl_t;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_COMP = 3'd1;
  localparam logic [2:0] RA_SRC  = 3'd2;
  localparam logic [2:0] RA_DST  = 3'd3;
  localparam logic [2:0] RA_CNT  = 3'd4;

endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       rd_ctrl,
  input  logic       wr_comp,
  input  logic [7:0] wdata,
  input  logic       tc,
  output ctrl_t      ctrl,
  output logic       master_en,
  output logic       auto_req,
  output logic       irq,
  output logic       arm,
  output logic       irq_clr
);

  ctrl_t wv;
  logic  rearm;

  assign wv      = ctrl_t'(wdata);
  // enable goes 0 -> 1 through a permitted write
  assign rearm   = wr_ctrl && wv.en && !ctrl.en && arm;
  assign irq_clr = wr_ctrl && (!wv.ie || rearm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      arm       <= 1'b0;
      master_en <= 1'b0;
      auto_req  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl    <= wv;
        ctrl.en <= wv.en && (ctrl.en || arm);
      end
      if (tc) ctrl.en <= 1'b0;

      if (rd_ctrl && !ctrl.en) arm <= 1'b1;
      else if (wr_ctrl)        arm <= 1'b0;

      if (wr_comp) begin
        master_en <= wdata[0];
        auto_req  <= wdata[1];
      end

      if (tc && ctrl.ie) irq <= 1'b1;
      else if (irq_clr)  irq <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_src,
  input  logic          wr_dst,
  input  logic          wr_cnt,
  input  logic [15:0]   wdata,
  input  logic          xfer_done,
  input  logic          word,
  input  logic          step,
  input  logic          dec,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic          last
);

  function automatic logic [AW-1:0] unit_amt(input logic w);
    return w ? AW'(2) : AW'(1);
  endfunction

  function automatic logic [AW-1:0] src_after(input logic [AW-1:0] a, input logic w,
                                              input logic s, input logic d);
    if (!s) return a;
    if (d)  return a - unit_amt(w);
    return a + unit_amt(w);
  endfunction

  function automatic logic [AW-1:0] dst_after(input logic [AW-1:0] a, input logic w);
    return a + unit_amt(w);
  endfunction

  assign last = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      dst <= '0;
      cnt <= '0;
    end else begin
      if (wr_src)         src <= wdata[AW-1:0];
      else if (xfer_done) src <= src_after(src, word, step, dec);

      if (wr_dst)         dst <= wdata[AW-1:0];
      else if (xfer_done) dst <= dst_after(dst, word);

      if (wr_cnt)         cnt <= wdata[CW-1:0];
      else if (xfer_done) cnt <= cnt - CW'(1);
    end
  end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          auto_req,
  input  logic          block_mode,
  input  logic          dreq,
  input  logic          last,
  input  logic          word,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [15:0]   bus_rdata,
  input  logic          bus_ack,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  output logic          start,
  output logic          xfer_done,
  output logic          tc
);

  phase_t      ph;
  logic        burst_q;
  logic [15:0] data_q;
  logic        want;

  assign want      = auto_req || burst_q || dreq;
  assign start     = (ph == PH_IDLE) && active && want;
  assign xfer_done = (ph == PH_WRITE) && bus_ack;
  assign tc        = xfer_done && last;

  assign bus_req   = (ph != PH_IDLE);
  assign bus_we    = (ph == PH_WRITE);
  assign bus_addr  = (ph == PH_WRITE) ? dst : src;
  assign bus_wdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      burst_q <= 1'b0;
      data_q  <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph <= PH_READ;
          if (block_mode && dreq) burst_q <= 1'b1;
        end
        PH_READ: if (bus_ack) begin
          data_q <= word ? bus_rdata : {8'h00, bus_rdata[7:0]};
          ph     <= PH_WRITE;
        end
        PH_WRITE: if (bus_ack) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
      if (tc || !active) burst_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cpu_addr,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [15:0]   cpu_wdata,
  output logic [15:0]   cpu_rdata,
  input  logic          dreq,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_word,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata,
  input  logic          bus_ack,
  output logic          irq
);

  ctrl_t         ctrl_q;
  logic          master_en, auto_req, ctrl_arm, irq_clr;
  logic          chan_en, full_mode, active;
  logic          seq_start, seq_done, seq_tc, cnt_last;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;

  assign chan_en   = ctrl_q.en;
  assign full_mode = ctrl_q.mode[2] && ctrl_q.mode[1];
  assign active    = chan_en && master_en && full_mode;
  assign bus_word  = ctrl_q.word;

  dma_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (cpu_wr && cpu_addr == RA_CTRL),
    .rd_ctrl   (cpu_rd && cpu_addr == RA_CTRL),
    .wr_comp   (cpu_wr && cpu_addr == RA_COMP),
    .wdata     (cpu_wdata[7:0]),
    .tc        (seq_tc),
    .ctrl      (ctrl_q),
    .master_en (master_en),
    .auto_req  (auto_req),
    .irq       (irq),
    .arm       (ctrl_arm),
    .irq_clr   (irq_clr)
  );

  dma_addr_unit #(.AW(AW), .CW(CW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_src    (cpu_wr && cpu_addr == RA_SRC),
    .wr_dst    (cpu_wr && cpu_addr == RA_DST),
    .wr_cnt    (cpu_wr && cpu_addr == RA_CNT),
    .wdata     (cpu_wdata),
    .xfer_done (seq_done),
    .word      (ctrl_q.word),
    .step      (ctrl_q.step),
    .dec       (ctrl_q.dec),
    .src       (src_q),
    .dst       (dst_q),
    .cnt       (cnt_q),
    .last      (cnt_last)
  );

  dma_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .auto_req   (auto_req),
    .block_mode (ctrl_q.mode[0]),
    .dreq       (dreq),
    .last       (cnt_last),
    .word       (ctrl_q.word),
    .src        (src_q),
    .dst        (dst_q),
    .bus_rdata  (bus_rdata),
    .bus_ack    (bus_ack),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .start      (seq_start),
    .xfer_done  (seq_done),
    .tc         (seq_tc)
  );

  always_comb begin
    case (cpu_addr)
      RA_CTRL: cpu_rdata = {8'h00, ctrl_q};
      RA_COMP: cpu_rdata = {14'd0, auto_req, master_en};
      RA_SRC:  cpu_rdata = 16'(src_q);
      RA_DST:  cpu_rdata = 16'(dst_q);
      RA_CNT:  cpu_rdata = 16'(cnt_q);
      default: cpu_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic tc,
  input logic ctrl_en,
  input logic master_en,
  input logic full_mode,
  input logic arm,
  input logic irq,
  input logic irq_clr,
  input logic bus_req,
  input logic bus_we
);

  // R4
  start_needs_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (ctrl_en && master_en));

  // R5
  start_needs_full_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> full_mode);

  // R3
  enable_rise_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_en) |-> $past(arm));

  // R9
  terminal_clears_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !ctrl_en);

  // R10
  irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R6
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we) |-> $past(bus_req && !bus_we));

endmodule

bind dma_chan_seq dma_chan_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (seq_start),
  .tc        (seq_tc),
  .ctrl_en   (chan_en),
  .master_en (master_en),
  .full_mode (full_mode),
  .arm       (ctrl_arm),
  .irq       (irq),
  .irq_clr   (irq_clr),
  .bus_req   (bus_req),
  .bus_we    (bus_we)
);

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cpu_addr;
  logic        cpu_wr, cpu_rd;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic        dreq;
  logic        bus_req, bus_we, bus_word, bus_ack, irq;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;

  logic [7:0]  mem [0:255];

  // behavioural model state
  logic [15:0] m_src, m_dst, m_cnt, exp_data, rd;
  logic        m_en, m_arm, m_word, m_dec, m_step, m_ie, m_irq;
  int          m_xfers, n_chk, n_fail, base;

  always #5 clk = ~clk;

  assign bus_ack   = bus_req;
  assign bus_rdata = {mem[bus_addr[7:0] + 8'd1], mem[bus_addr[7:0]]};

  dma_chan_seq u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dreq(dreq), .bus_req(bus_req),
    .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq(irq)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic cpu_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(posedge clk);
    #1 cpu_wr = 1'b0;
    case (a)
      3'd0: begin
        if (d[7] && !m_en && m_arm) m_irq = 1'b0;
        if (!d[3]) m_irq = 1'b0;
        m_en = d[7] && (m_en || m_arm);
        m_arm = 1'b0;
        m_word = d[6]; m_dec = d[5]; m_step = d[4]; m_ie = d[3];
      end
      3'd2: m_src = d;
      3'd3: m_dst = d;
      3'd4: m_cnt = d;
      default: ;
    endcase
  endtask

  task automatic cpu_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1 d = cpu_rdata;
    @(posedge clk);
    #1 cpu_rd = 1'b0;
    if (a == 3'd0 && !m_en) m_arm = 1'b1;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    dreq = 1'b1;
    @(posedge clk);
    #1 dreq = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; m_xfers = 0;
    m_src = '0; m_dst = '0; m_cnt = '0; exp_data = '0;
    m_en = 0; m_arm = 0; m_word = 0; m_dec = 0; m_step = 0; m_ie = 0; m_irq = 0;
    cpu_addr = '0; cpu_wr = 0; cpu_rd = 0; cpu_wdata = '0; dreq = 0;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    rst_n = 1'b0;

    fork
      begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
      end
      begin : monitor
        forever begin
          @(negedge clk);
          if (rst_n) begin
            chk("R10 irq vs model", irq, m_irq);
            if (bus_req && !bus_we) begin
              chk("R7 source address", bus_addr, m_src);
              chk("R6 read size", bus_word, m_word);
              exp_data = m_word ? {mem[bus_addr[7:0] + 8'd1], mem[bus_addr[7:0]]}
                                : {8'h00, mem[bus_addr[7:0]]};
            end else if (bus_req && bus_we) begin
              chk("R8 destination address", bus_addr, m_dst);
              chk("R6 write data", bus_wdata, exp_data);
              mem[bus_addr[7:0]] = bus_wdata[7:0];
              if (m_word) mem[bus_addr[7:0] + 8'd1] = bus_wdata[15:8];
              if (m_step) m_src = m_dec ? m_src - (m_word ? 16'd2 : 16'd1)
                                        : m_src + (m_word ? 16'd2 : 16'd1);
              m_dst = m_dst + (m_word ? 16'd2 : 16'd1);
              m_cnt = m_cnt - 16'd1;
              m_xfers++;
              if (m_cnt == 16'd0) begin
                m_en = 1'b0;
                if (m_ie) m_irq = 1'b1;
              end
            end
          end
        end
      end
    join_none

    // R2 reset state
    repeat (3) @(negedge clk);
    chk("R2 bus_req in reset", bus_req, 1'b0);
    chk("R2 irq in reset", irq, 1'b0);
    rst_n = 1'b1;
    cpu_read(3'd0, rd); chk("R2 R1 control reset value", rd, 16'h0000);
    cpu_read(3'd1, rd); chk("R2 R1 companion reset value", rd, 16'h0000);

    // R3: an intervening write uses up the permission
    cpu_write(3'd0, 16'h0007);
    cpu_write(3'd0, 16'h0087);
    cpu_read(3'd0, rd); chk("R3 enable refused without read", rd, 16'h0007);

    // R4: armed enable but master off, auto-request selected
    cpu_write(3'd2, 16'h0010);
    cpu_write(3'd3, 16'h0080);
    cpu_write(3'd4, 16'h0004);
    cpu_write(3'd1, 16'h0002);
    cpu_write(3'd0, 16'h009E);
    cpu_read(3'd0, rd); chk("R3 enable set after read", rd, 16'h009E);
    repeat (10) @(negedge clk);
    chk("R4 no transfer with master off", m_xfers, 0);

    // R5: incomplete mode code
    cpu_write(3'd0, 16'h009A);
    cpu_write(3'd1, 16'h0003);
    cpu_read(3'd1, rd); chk("R1 companion readback", rd, 16'h0003);
    repeat (10) @(negedge clk);
    chk("R5 no transfer without full mode", m_xfers, 0);

    // R11 auto-request, byte, ascending source
    cpu_write(3'd0, 16'h009E);
    repeat (30) @(negedge clk);
    chk("R11 auto transfers done", m_xfers, 4);
    cpu_read(3'd4, rd); chk("R9 count at zero", rd, 16'h0000);
    cpu_read(3'd0, rd); chk("R9 enable self-cleared", rd, 16'h001E);
    cpu_read(3'd2, rd); chk("R7 final source", rd, 16'h0014);
    cpu_read(3'd3, rd); chk("R8 final destination", rd, 16'h0084);
    for (int i = 0; i < 4; i++) chk("R6 byte copied", mem[8'h80 + i], pat(8'h10 + i));
    chk("R10 irq raised", irq, 1'b1);
    repeat (5) @(negedge clk);
    chk("R10 irq held", irq, 1'b1);
    cpu_write(3'd0, 16'h0016);
    @(negedge clk);
    chk("R10 irq cleared by ie=0", irq, 1'b0);

    // word transfers, descending source
    cpu_write(3'd2, 16'h0040);
    cpu_write(3'd3, 16'h00A0);
    cpu_write(3'd4, 16'h0003);
    cpu_read(3'd0, rd);
    cpu_write(3'd0, 16'h00FE);
    repeat (30) @(negedge clk);
    chk("R9 word transfers done", m_xfers, 7);
    cpu_read(3'd2, rd); chk("R7 descending word source", rd, 16'h003A);
    cpu_read(3'd3, rd); chk("R8 word destination", rd, 16'h00A6);
    for (int k = 0; k < 3; k++) begin
      base = 8'h40 - 2 * k;
      chk("R6 word low byte", mem[8'hA0 + 2 * k], pat(base));
      chk("R6 word high byte", mem[8'hA1 + 2 * k], pat(base + 1));
    end
    chk("R10 irq after word run", irq, 1'b1);

    // R11 external requests, held source; re-arm clears irq
    cpu_write(3'd2, 16'h0020);
    cpu_write(3'd3, 16'h00C0);
    cpu_write(3'd4, 16'h0003);
    cpu_write(3'd1, 16'h0001);
    cpu_read(3'd0, rd);
    cpu_write(3'd0, 16'h008E);
    @(negedge clk);
    chk("R10 irq cleared by re-arm", irq, 1'b0);
    repeat (10) @(negedge clk);
    chk("R11 waits for request", m_xfers, 7);
    pulse_req();
    repeat (6) @(negedge clk);
    chk("R11 one transfer per request", m_xfers, 8);
    pulse_req(); repeat (6) @(negedge clk);
    pulse_req(); repeat (6) @(negedge clk);
    chk("R11 three requests", m_xfers, 10);
    cpu_read(3'd2, rd); chk("R7 held source", rd, 16'h0020);
    for (int i = 0; i < 3; i++) chk("R6 held copy", mem[8'hC0 + i], pat(8'h20));
    pulse_req();
    repeat (6) @(negedge clk);
    chk("R11 request ignored while disabled", m_xfers, 10);
    chk("R11 bus idle while disabled", bus_req, 1'b0);

    // R12 block mode
    cpu_write(3'd0, 16'h000E);
    cpu_write(3'd2, 16'h0050);
    cpu_write(3'd3, 16'h00D0);
    cpu_write(3'd4, 16'h0004);
    cpu_read(3'd0, rd);
    cpu_write(3'd0, 16'h009F);
    repeat (8) @(negedge clk);
    chk("R12 block waits for request", m_xfers, 10);
    pulse_req();
    repeat (30) @(negedge clk);
    chk("R12 single request drains count", m_xfers, 14);
    cpu_read(3'd4, rd); chk("R12 count zero after block", rd, 16'h0000);
    for (int i = 0; i < 4; i++) chk("R12 block data", mem[8'hD0 + i], pat(8'h50 + i));

    summary();
  end

endmodule